// File: doc/BRIEF.md
# Nonvolatile Store/Recall Controller

This block controls the copying of data between a small volatile working RAM and a shadow nonvolatile array behind it. Three control latches gate the copies: a write-permit latch, an auto-save latch and a recalled-once latch. A serial front end decodes instructions and passes them in as single-cycle strobes. The block also takes a power-good level and a supply-fail level from board-level supervision.

When power comes up, the controller first waits a fixed number of cycles and loads the RAM from the shadow array. A host can then read and write RAM words, ask for a recall from the shadow array, or ask for a save into it. With auto-save armed, a supply-fail event triggers a save without any command. A save is allowed only after the host has itself run a recall at least once since power came up. The recall made at power-up does not count, so the shadow array cannot be overwritten with RAM contents that were never confirmed. Each copy runs for a parameterised number of cycles. During that time the block reports busy and drops commands. A save that is refused produces a one-cycle error pulse.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: After asynchronous reset, with power-good low, busy_o is 1, the three latch outputs and blocked_o are 0, and every RAM word reads 0.
- R2: Power-up works as follows. At the first clock edge that samples pwr_good_i high, the power-up load starts. busy_o stays 1 for PUR_CYCLES more edges and then drops. The RAM then holds the shadow contents. After a reset the shadow word i is (i*0x0123 + 0x5A3C) mod 2^16. recall_latch_o stays 0.
- R3: While busy_o is 1, the block drops every strobe, supply-fail event and RAM write. The latches and the RAM keep their values.
- R4: wr_en_i sets wr_latch_o. wr_dis_i clears it. When both are given in the same cycle, the clear wins. auto_en_i sets auto_latch_o. Latch strobes take effect only when the block is idle.
- R5: A recall strobe holds busy_o high for XFER_CYCLES cycles. The RAM is then loaded from the shadow array and recall_latch_o becomes 1.
- R6: A store strobe starts a save only when wr_latch_o and recall_latch_o are both 1. A save holds busy_o high for XFER_CYCLES cycles, then copies the RAM into the shadow array and leaves all latches unchanged. A refused store raises blocked_o for one cycle and does not go busy.
- R7: A rising edge of supply_fail_i starts a save when auto_latch_o, wr_latch_o and recall_latch_o are all 1.
- R8: A rising edge of supply_fail_i in the idle state, without all three latches set, starts no save and raises blocked_o for one cycle. A level held high produces no further events.
- R9: A low pwr_good_i clears all three latches, aborts any running copy without changing either array, and keeps busy_o at 1 until the next power-up load completes.
- R10: When several requests arrive in the same idle cycle, a supply-fail edge takes precedence over recall, and recall over store. A RAM write in a cycle that carries any of these requests is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply present and stable |
| supply_fail_i | input | 1 | Supply falling; its rising edge is an event |
| wr_en_i | input | 1 | Strobe: set write-permit latch |
| wr_dis_i | input | 1 | Strobe: clear write-permit latch |
| auto_en_i | input | 1 | Strobe: arm auto-save latch |
| store_i | input | 1 | Strobe: save RAM to shadow array |
| recall_i | input | 1 | Strobe: load RAM from shadow array |
| ram_we_i | input | 1 | RAM word write enable |
| ram_addr_i | input | AW | RAM word address for read and write |
| ram_wdata_i | input | WIDTH | RAM write data |
| ram_rdata_o | output | WIDTH | RAM word at ram_addr_i |
| busy_o | output | 1 | Copy or power-up in progress |
| wr_latch_o | output | 1 | Write-permit latch |
| auto_latch_o | output | 1 | Auto-save latch |
| recall_latch_o | output | 1 | Recalled-once latch |
| blocked_o | output | 1 | One-cycle pulse on a refused save |

## Verification
A wrong latch value shows up on the latch outputs at the next edge. It also changes whether the following store or supply-fail event goes busy or pulses blocked_o, which decides in the same cycle whether a save is taken or refused. A wrong copy count shows as busy_o falling one or more cycles early or late. A copy in the wrong direction, or a missing copy, stays hidden in the arrays until a later recall brings the shadow data back. The RAM is therefore swept word by word after each recall, and the RAM contents are compared every cycle.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_PUR,
    ST_IDLE,
    ST_STORE,
    ST_RECALL
  } nvc_state_e;

  // factory content of shadow word i
  function automatic logic [31:0] nv_seed(int unsigned idx);
    return idx * 32'h0000_0123 + 32'h0000_5A3C;
  endfunction
endpackage

// File: rtl/nvc_latches.sv
module nvc_latches (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic upd_en_i,
  input  logic wr_en_i,
  input  logic wr_dis_i,
  input  logic auto_en_i,
  input  logic set_rcl_i,
  output logic wel_o,
  output logic asel_o,
  output logic rcl_o
);
  logic wel_q, asel_q, rcl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      asel_q <= 1'b0;
      rcl_q  <= 1'b0;
    end else if (!pwr_good_i) begin
      wel_q  <= 1'b0;
      asel_q <= 1'b0;
      rcl_q  <= 1'b0;
    end else begin
      if (upd_en_i) begin
        if (wr_dis_i)     wel_q <= 1'b0;
        else if (wr_en_i) wel_q <= 1'b1;
        if (auto_en_i)    asel_q <= 1'b1;
      end
      if (set_rcl_i) rcl_q <= 1'b1;
    end
  end

  assign wel_o  = wel_q;
  assign asel_o = asel_q;
  assign rcl_o  = rcl_q;
endmodule

// File: rtl/nvc_seq.sv
module nvc_seq
  import nvc_pkg::*;
#(
  parameter int unsigned PUR_CYCLES  = 20,
  parameter int unsigned XFER_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic supply_fail_i,
  input  logic store_i,
  input  logic recall_i,
  input  logic wel_i,
  input  logic asel_i,
  input  logic rcl_i,
  output logic busy_o,
  output logic idle_en_o,
  output logic take_o,
  output logic ram_load_o,
  output logic nv_load_o,
  output logic set_rcl_o,
  output logic err_o
);
  localparam int unsigned MAXC = (PUR_CYCLES > XFER_CYCLES) ? PUR_CYCLES : XFER_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PUR_LAST  = CW'(PUR_CYCLES - 1);
  localparam logic [CW-1:0] XFER_LAST = CW'(XFER_CYCLES - 1);

  nvc_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic sf_q, sf_rise, save_ok, idle, err_d;

  assign sf_rise = supply_fail_i & ~sf_q;
  assign save_ok = wel_i & rcl_i;
  assign idle    = (st_q == ST_IDLE) & pwr_good_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    err_d = 1'b0;
    if (!pwr_good_i) begin
      st_d  = ST_OFF;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_d  = ST_PUR;
          cnt_d = '0;
        end
        ST_PUR: begin
          if (cnt_q == PUR_LAST) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_IDLE: begin
          if (sf_rise) begin
            if (asel_i && save_ok) st_d = ST_STORE;
            else err_d = 1'b1;
          end else if (recall_i) begin
            st_d = ST_RECALL;
          end else if (store_i) begin
            if (save_ok) st_d = ST_STORE;
            else err_d = 1'b1;
          end
          cnt_d = '0;
        end
        ST_STORE, ST_RECALL: begin
          if (cnt_q == XFER_LAST) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
      sf_q  <= 1'b0;
      err_o <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sf_q  <= supply_fail_i;
      err_o <= err_d;
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign idle_en_o  = idle;
  assign take_o     = idle & (sf_rise | recall_i | store_i);
  assign ram_load_o = pwr_good_i & (((st_q == ST_PUR) & (cnt_q == PUR_LAST)) |
                                    ((st_q == ST_RECALL) & (cnt_q == XFER_LAST)));
  assign nv_load_o  = pwr_good_i & (st_q == ST_STORE) & (cnt_q == XFER_LAST);
  assign set_rcl_o  = pwr_good_i & (st_q == ST_RECALL) & (cnt_q == XFER_LAST);
endmodule

// File: rtl/nvc_arrays.sv
module nvc_arrays
  import nvc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             ram_load_i,
  input  logic             nv_load_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] ram_q [DEPTH];
  logic [WIDTH-1:0] nv_q  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [31:0] SEED = nv_seed(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ram_q[i] <= '0;
      else if (ram_load_i) ram_q[i] <= nv_q[i];
      else if (we_i && (addr_i == AW'(i))) ram_q[i] <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) nv_q[i] <= SEED[WIDTH-1:0];
      else if (nv_load_i) nv_q[i] <= ram_q[i];
    end
  end

  assign rdata_o = ram_q[addr_i];
endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl #(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned PUR_CYCLES  = 20,
  parameter int unsigned XFER_CYCLES = 8,
  localparam int unsigned AW         = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             supply_fail_i,
  input  logic             wr_en_i,
  input  logic             wr_dis_i,
  input  logic             auto_en_i,
  input  logic             store_i,
  input  logic             recall_i,
  input  logic             ram_we_i,
  input  logic [AW-1:0]    ram_addr_i,
  input  logic [WIDTH-1:0] ram_wdata_i,
  output logic [WIDTH-1:0] ram_rdata_o,
  output logic             busy_o,
  output logic             wr_latch_o,
  output logic             auto_latch_o,
  output logic             recall_latch_o,
  output logic             blocked_o
);
  logic idle_en, take, ram_load, nv_load, set_rcl;

  nvc_seq #(
    .PUR_CYCLES (PUR_CYCLES),
    .XFER_CYCLES(XFER_CYCLES)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_good_i   (pwr_good_i),
    .supply_fail_i(supply_fail_i),
    .store_i      (store_i),
    .recall_i     (recall_i),
    .wel_i        (wr_latch_o),
    .asel_i       (auto_latch_o),
    .rcl_i        (recall_latch_o),
    .busy_o       (busy_o),
    .idle_en_o    (idle_en),
    .take_o       (take),
    .ram_load_o   (ram_load),
    .nv_load_o    (nv_load),
    .set_rcl_o    (set_rcl),
    .err_o        (blocked_o)
  );

  nvc_latches u_latches (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_good_i(pwr_good_i),
    .upd_en_i  (idle_en),
    .wr_en_i   (wr_en_i),
    .wr_dis_i  (wr_dis_i),
    .auto_en_i (auto_en_i),
    .set_rcl_i (set_rcl),
    .wel_o     (wr_latch_o),
    .asel_o    (auto_latch_o),
    .rcl_o     (recall_latch_o)
  );

  nvc_arrays #(
    .DEPTH(DEPTH),
    .WIDTH(WIDTH)
  ) u_arrays (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ram_we_i & idle_en & ~take),
    .addr_i    (ram_addr_i),
    .wdata_i   (ram_wdata_i),
    .ram_load_i(ram_load),
    .nv_load_i (nv_load),
    .rdata_o   (ram_rdata_o)
  );
endmodule

// File: rtl/nvc_chk.sv
module nvc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_good_i,
  input logic wr_dis_i,
  input logic busy_o,
  input logic wr_latch_o,
  input logic auto_latch_o,
  input logic recall_latch_o,
  input logic blocked_o
);
  // R9
  off_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (busy_o && !wr_latch_o && !auto_latch_o && !recall_latch_o));

  // R3
  busy_holds_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && pwr_good_i) |=> $stable({wr_latch_o, auto_latch_o}));

  // R5
  recall_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recall_latch_o) |-> $fell(busy_o));

  // R6
  blocked_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_o |-> !busy_o);

  // R4
  wr_dis_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && pwr_good_i && wr_dis_i) |=> !wr_latch_o);
endmodule

bind nv_xfer_ctrl nvc_chk u_nvc_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pwr_good_i    (pwr_good_i),
  .wr_dis_i      (wr_dis_i),
  .busy_o        (busy_o),
  .wr_latch_o    (wr_latch_o),
  .auto_latch_o  (auto_latch_o),
  .recall_latch_o(recall_latch_o),
  .blocked_o     (blocked_o)
);

// File: tb/nv_xfer_ctrl_bench.sv
module nv_xfer_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 16;
  localparam int PUR   = 20;
  localparam int XFER  = 8;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 0, sf = 0, wren = 0, wrdis = 0, asen = 0, store = 0, recall = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [WIDTH-1:0] wdata = '0;
  logic [WIDTH-1:0] rdata;
  logic busy, wel, asel, rcl, blk;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nv_xfer_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PUR_CYCLES(PUR), .XFER_CYCLES(XFER)) u_nv_xfer_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .supply_fail_i(sf),
    .wr_en_i(wren), .wr_dis_i(wrdis), .auto_en_i(asen), .store_i(store), .recall_i(recall),
    .ram_we_i(we), .ram_addr_i(addr), .ram_wdata_i(wdata), .ram_rdata_o(rdata),
    .busy_o(busy), .wr_latch_o(wel), .auto_latch_o(asel), .recall_latch_o(rcl), .blocked_o(blk)
  );

  // behavioural reference: 0 off, 1 power-up, 2 idle, 3 save, 4 recall
  int m_st, m_cnt;
  bit m_wel, m_asel, m_rcl, m_err, m_sfq;
  int m_ram [DEPTH];
  int m_nv  [DEPTH];
  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1";

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_wel = 0; m_asel = 0; m_rcl = 0; m_err = 0; m_sfq = 0;
    for (int i = 0; i < DEPTH; i++) begin
      m_ram[i] = 0;
      m_nv[i] = (i * 'h0123 + 'h5A3C) & 'hFFFF;
    end
  endtask

  task automatic model_step();
    bit rise, ok;
    rise = sf && !m_sfq;
    m_sfq = sf;
    m_err = 0;
    if (!pg) begin
      m_st = 0; m_cnt = 0; m_wel = 0; m_asel = 0; m_rcl = 0;
    end else if (m_st == 0) begin
      m_st = 1; m_cnt = 0;
    end else if (m_st == 1) begin
      if (m_cnt == PUR - 1) begin
        for (int i = 0; i < DEPTH; i++) m_ram[i] = m_nv[i];
        m_st = 2; m_cnt = 0;
      end else m_cnt++;
    end else if (m_st == 2) begin
      ok = m_wel && m_rcl;
      if (rise) begin
        if (m_asel && ok) m_st = 3; else m_err = 1;
      end else if (recall) m_st = 4;
      else if (store) begin
        if (ok) m_st = 3; else m_err = 1;
      end else if (we) m_ram[addr] = int'(wdata);
      if (wrdis) m_wel = 0; else if (wren) m_wel = 1;
      if (asen) m_asel = 1;
      m_cnt = 0;
    end else begin
      if (m_cnt == XFER - 1) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (m_st == 3) m_nv[i] = m_ram[i]; else m_ram[i] = m_nv[i];
        end
        if (m_st == 4) m_rcl = 1;
        m_st = 2; m_cnt = 0;
      end else m_cnt++;
    end
  endtask

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("busy_o", int'(busy), int'(m_st != 2));
    chk("wr_latch_o", int'(wel), int'(m_wel));
    chk("auto_latch_o", int'(asel), int'(m_asel));
    chk("recall_latch_o", int'(rcl), int'(m_rcl));
    chk("blocked_o", int'(blk), int'(m_err));
    chk("ram_rdata_o", int'(rdata), m_ram[addr]);
  endtask

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      if (rst_n) model_step();
      #1;
      compare();
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  task automatic sweep();
    for (int i = 0; i < DEPTH; i++) begin
      addr = AW'(i); cyc(1);
    end
  endtask

  task automatic wr_word(int a, int d);
    addr = AW'(a); wdata = WIDTH'(d); we = 1'b1; cyc(1); we = 1'b0;
  endtask

  initial begin
    model_reset();
    #(CLK_PERIOD * 2 + 2);
    compare();             // R1 reset state
    rst_n = 1'b1;
    cur_req = "R1"; sweep(); cyc(2);

    // R2 power-up load; R3 strobes and writes dropped during it
    cur_req = "R2"; pg = 1'b1; cyc(3);
    cur_req = "R3"; wren = 1; asen = 1; recall = 1; we = 1; addr = 4'd2; wdata = 16'hDEAD;
    cyc(1); wren = 0; asen = 0; recall = 0; we = 0;
    cur_req = "R2"; cyc(PUR); sweep();

    // R6 store refused without latches
    cur_req = "R6"; pulse(store); cyc(1);
    cur_req = "R4"; pulse(wren); cyc(1);
    cur_req = "R6"; pulse(store); cyc(1);   // refused: recalled-once still clear
    cur_req = "R4"; wrdis = 1; wren = 1; cyc(1); wrdis = 0; wren = 0; cyc(1);
    pulse(wren); pulse(wrdis); pulse(wren);

    // R5 recall overrides written RAM words
    cur_req = "R5";
    for (int i = 0; i < DEPTH; i++) wr_word(i, 'h1000 + i * 7);
    sweep();
    pulse(recall);
    cur_req = "R3"; we = 1; addr = 4'd5; wdata = 16'hBEEF; wrdis = 1; cyc(2);
    we = 0; wrdis = 0;
    cur_req = "R5"; cyc(XFER); sweep();

    // R6 permitted save, then restore via recall
    cur_req = "R6";
    for (int i = 0; i < DEPTH; i++) wr_word(i, 'hC300 ^ (i * 'h0111));
    pulse(store); cyc(XFER + 1);
    for (int i = 0; i < DEPTH; i++) wr_word(i, 0);
    pulse(recall); cyc(XFER + 1); sweep();

    // R8 supply-fail edge without auto-save armed, held level
    cur_req = "R8"; sf = 1; cyc(4); sf = 0; cyc(1);
    // R7 auto-save
    cur_req = "R7"; pulse(asen); cyc(1);
    for (int i = 0; i < DEPTH; i++) wr_word(i, 'h7E00 + i);
    sf = 1; cyc(XFER + 2); sf = 0; cyc(1);
    for (int i = 0; i < DEPTH; i++) wr_word(i, 'hFFFF);
    pulse(recall); cyc(XFER + 1); sweep();

    // R10 priorities and dropped write
    cur_req = "R10"; recall = 1; store = 1; we = 1; addr = 4'd3; wdata = 16'h1234;
    cyc(1); recall = 0; store = 0; we = 0; cyc(XFER + 1);
    wr_word(3, 'h5555);
    sf = 1; recall = 1; cyc(1); sf = 0; recall = 0; cyc(XFER + 1);
    addr = 4'd3; cyc(1);
    wr_word(3, 'h6666); pulse(recall); cyc(XFER + 1); addr = 4'd3; cyc(1);

    // R9 power loss mid-save
    cur_req = "R9";
    for (int i = 0; i < DEPTH; i++) wr_word(i, 'h0F0F);
    pulse(store); cyc(3); pg = 0; cyc(3);
    pulse(wren); pulse(store);
    pg = 1; cyc(PUR + 2); sweep();
    cur_req = "R8"; pulse(store); sf = 1; cyc(2); sf = 0; cyc(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL %s watchdog actual=%0d expected<=20000", cur_req, cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule